// File: doc/BRIEF.md
# Floating-Point Exception Mask Unit

This block sits beside a floating-point datapath and turns the exception causes that the datapath reports into sticky status flags. A 16-bit control word holds one mask bit per cause. A cause whose mask bit is set is handled automatically: the block tells the datapath, in the same cycle, to substitute its default result. For example, a masked divide by zero produces infinity and execution carries on. A cause whose mask bit is clear stays pending and raises a handler request.

The integer side can issue a wait/synchronize request. While any unmasked exception is pending, that request is held stalled, so no integer instruction runs ahead of a faulting floating-point operation. Software-style writes replace the whole control word. A clear command wipes the sticky flags, which ends the handler request and releases the stall.

Top module: `fp_exc_ctl`

## Requirements
- R1: After reset the control word reads 0x003F, so all six causes are masked. The status word reads 0, and neither the handler request nor the stall is asserted.
- R2: A control-word write loads all 16 bits of the written value, and the new value is visible on the cycle after the write.
- R3: Status flags bits 0 to 5 are sticky. A set flag stays set until a clear command, whatever later exceptions or control writes occur.
- R4: A reported exception sets the matching status flag on the next cycle. The bit positions are: bit 0 invalid operation, bit 1 denormal operand, bit 2 divide by zero, bit 3 overflow, bit 4 underflow, bit 5 inexact. The mask bits in the control word use the same positions.
- R5: A clear command zeroes the status flags on the next cycle. An exception reported in the same cycle as the clear is still recorded.
- R6: Status bit 7 is the error summary, the OR of the flags whose mask bit is clear. The handler request equals this summary. Status bits 6 and 15:8 read 0.
- R7: A control-word write that clears the mask of a flag that is already set raises the handler request on the next cycle.
- R8: In the same cycle as a report, the default-result output equals the reported causes ANDed with their mask bits. For example, bit 2 asks the datapath for infinity on a masked divide by zero. The output is 0 when no exception is reported.
- R9: The stall output is high exactly when the wait input is high and an unmasked exception is pending. It drops on the cycle after a clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Datapath reports exception causes this cycle |
| exc_cause | input | 6 | Reported causes, one bit per cause |
| cw_we | input | 1 | Control-word write strobe |
| cw_wdata | input | 16 | Control-word write value |
| exc_clear | input | 1 | Clear all sticky flags |
| sync_wait | input | 1 | Integer side waits for pending exceptions |
| ctrl_word | output | 16 | Current control word |
| stat_word | output | 16 | Sticky flags and error summary |
| trap_req | output | 1 | Handler request |
| sync_stall | output | 1 | Hold the integer side |
| dflt_fix | output | 6 | Masked causes for which the datapath substitutes a default result |

## Verification
The assertions assume clean inputs. Strobes are never X while reset is released, and the datapath drives the cause bits as meaningful only when its valid bit is high. The bench drives every input on a fixed phase away from the clock edge. It sweeps all 64 mask settings against all 64 cause patterns, and each pattern is started from a cleared state so that the expected flags follow from that pattern alone. Clear and report in the same cycle is exercised on its own, with both the report and the clear known in advance.

// File: rtl/fp_exc_ctl.sv
module fp_exc_ctl #(
  parameter int NCAUSE = 6,
  parameter int CW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [NCAUSE-1:0] exc_cause,
  input  logic              cw_we,
  input  logic [CW_W-1:0]   cw_wdata,
  input  logic              exc_clear,
  input  logic              sync_wait,
  output logic [CW_W-1:0]   ctrl_word,
  output logic [CW_W-1:0]   stat_word,
  output logic              trap_req,
  output logic              sync_stall,
  output logic [NCAUSE-1:0] dflt_fix
);
  localparam int SUM_BIT = 7;
  localparam logic [CW_W-1:0] CW_RST = CW_W'((1 << NCAUSE) - 1);

  logic [CW_W-1:0]   cw_q;
  logic [NCAUSE-1:0] flag_q;
  logic [NCAUSE-1:0] masks;
  logic [NCAUSE-1:0] new_exc;
  logic              summary;

  assign masks   = cw_q[NCAUSE-1:0];
  assign new_exc = exc_valid ? exc_cause : '0;
  assign summary = |(flag_q & ~masks);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_q   <= CW_RST;
      flag_q <= '0;
    end else begin
      if (cw_we) cw_q <= cw_wdata;
      flag_q <= (exc_clear ? '0 : flag_q) | new_exc;
    end
  end

  always_comb begin
    stat_word                 = '0;
    stat_word[NCAUSE-1:0]     = flag_q;
    stat_word[SUM_BIT]        = summary;
  end

  assign ctrl_word  = cw_q;
  assign trap_req   = summary;
  assign sync_stall = sync_wait & summary;
  assign dflt_fix   = new_exc & masks;

  a_r1_reset_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_word == CW_RST && stat_word == '0 && !trap_req));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_clear |=> ((stat_word[NCAUSE-1:0] & $past(stat_word[NCAUSE-1:0]))
                    == $past(stat_word[NCAUSE-1:0])));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> ((stat_word[NCAUSE-1:0] & $past(exc_cause)) == $past(exc_cause)));

  a_r7_unmask_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && !exc_clear && |(stat_word[NCAUSE-1:0] & ~cw_wdata[NCAUSE-1:0]))
      |=> trap_req);

  a_r8_fix_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((dflt_fix & ~ctrl_word[NCAUSE-1:0]) == '0) && (!exc_valid -> dflt_fix == '0));

  a_r9_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_clear && !exc_valid) |=> !sync_stall);
endmodule

// File: tb/fp_exc_ctl_test.sv
module fp_exc_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic        exc_valid, cw_we, exc_clear, sync_wait;
  logic [5:0]  exc_cause;
  logic [15:0] cw_wdata;
  logic [15:0] ctrl_word, stat_word;
  logic        trap_req, sync_stall;
  logic [5:0]  dflt_fix;

  int checks = 0;
  int fails  = 0;

  fp_exc_ctl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; exc_valid = 0; exc_cause = 0; cw_we = 0; cw_wdata = 0;
    exc_clear = 0; sync_wait = 0;
    #1;
    step(); step();
    rst_n = 1;
    #1;
    chk("R1 ctrl", ctrl_word, 16'h003F);
    chk("R1 stat", stat_word, 16'h0000);
    chk("R1 trap", {15'h0, trap_req}, 16'h0);
    chk("R1 stall", {15'h0, sync_stall}, 16'h0);

    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 64; f++) begin
        logic [15:0] cw;
        logic        pend;
        cw   = {10'(f * 13 + m), 6'(m)};
        pend = |(6'(f) & ~6'(m));
        exc_clear = 1; cw_we = 1; cw_wdata = cw; sync_wait = 1;
        exc_valid = 0; exc_cause = 6'(f);
        #1;
        chk("R8 idle", {10'h0, dflt_fix}, 16'h0);
        step();
        exc_clear = 0; cw_we = 0;
        chk("R2 write", ctrl_word, cw);
        chk("R5 cleared", stat_word, 16'h0);
        chk("R9 released", {15'h0, sync_stall}, 16'h0);
        exc_valid = 1;
        #1;
        chk("R8 default", {10'h0, dflt_fix}, {10'h0, 6'(f) & 6'(m)});
        step();
        exc_valid = 0;
        chk("R4 flags", {10'h0, stat_word[5:0]}, 16'(f));
        chk("R6 summary", {8'h0, stat_word[15:6]}, {8'h0, 8'h0, pend, 1'b0});
        chk("R6 trap", {15'h0, trap_req}, {15'h0, pend});
        chk("R9 stall", {15'h0, sync_stall}, {15'h0, pend});
        cw_we = 1; cw_wdata = 16'h0000;
        step();
        cw_we = 0;
        chk("R7 unmask", {15'h0, trap_req}, {15'h0, f != 0});
        chk("R3 sticky", {10'h0, stat_word[5:0]}, 16'(f));
      end
    end

    exc_clear = 1; cw_we = 1; cw_wdata = 16'h003F; sync_wait = 0;
    step();
    exc_clear = 0; cw_we = 0;
    exc_valid = 1; exc_cause = 6'b000011;
    step();
    exc_clear = 1; exc_cause = 6'b000100;
    step();
    exc_clear = 0; exc_valid = 0;
    chk("R5 clear with report", {10'h0, stat_word[5:0]}, 16'h0004);
    chk("R9 no wait", {15'h0, sync_stall}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule